// File: doc/BRIEF.md
# Parallel Instruction Boundary Aligner

This block sits between instruction fetch and an eight-slot decode stage. The instruction set mixes 16-bit and 32-bit instructions, and every instruction starts on a halfword boundary. Each cycle the aligner takes a window of sixteen consecutive halfwords that begins at the current fetch offset. A count says how many of the leading halfwords hold fetched data. In one pass the aligner finds where each of up to eight instructions begins and steers each one into its own decode slot. Every slot carries a valid flag, a 32-bit flag and the raw instruction word.

Instruction boundaries are not found by a scan. Each halfword contributes one length bit, the AND of its two lowest bits. A prefix over these bits gives every slot a one-hot start position. Slot 0 is fixed at halfword 0, and slot k can only begin somewhere between halfword k and halfword 2k, so the selector for a later slot is wider. The block also reports how many halfwords the valid slots used, and the fetch unit advances its pointer by that amount.

The results are registered, so they appear one clock after the window is presented. A stall from decode freezes the registered slots and forces the consumed count to zero.

Top module: `insn_aligner`

## Requirements
- R1: A halfword whose two lowest bits are 2'b11 begins a 32-bit instruction. Bit patterns 2'b00, 2'b01 and 2'b10 begin a 16-bit instruction, and the slot's long flag is set only for 32-bit instructions.
- R2: Slot 0 begins at halfword 0. Each later slot begins one halfword after the previous slot's start if that slot is 16-bit, or two halfwords after it if that slot is 32-bit.
- R3: The slot word of a 32-bit instruction has its first halfword in bits [15:0] and its second halfword in bits [31:16]. A 16-bit instruction sits in bits [15:0] with bits [31:16] zero.
- R4: A slot is valid only if every halfword of its instruction lies below the available count. This means a 32-bit instruction starting at the last available halfword, or at halfword 15, is not emitted.
- R5: Valid slots are contiguous from slot 0. Once one slot is invalid, every later slot is invalid.
- R6: At most eight slots are filled per window, even when more whole instructions are available.
- R7: While not stalled, the consumed count equals the sum of the lengths of the valid slots, in halfwords (1 for 16-bit, 2 for 32-bit).
- R8: An invalid slot drives an all-zero word and a clear long flag.
- R9: While the stall input is high, the slot outputs keep their values, any window change is ignored, and the consumed count reads zero.
- R10: During synchronous active-low reset, all slots are invalid, all words are zero and the consumed count is zero.
- R11: The slot outputs and consumed count for a window appear one clock edge after it is presented with stall low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_i | input | 256 | Sixteen halfwords; halfword i in bits [16i+15:16i] |
| avail_i | input | 5 | Number of leading halfwords that hold fetched data (0 to 16) |
| stall_i | input | 1 | Decode cannot accept; hold outputs |
| slot_valid_o | output | 8 | Per-slot valid, bit k for slot k |
| slot_long_o | output | 8 | Per-slot 32-bit flag |
| slot_word_o | output | 256 | Slot k word in bits [32k+31:32k] |
| consumed_o | output | 5 | Halfwords used by the valid slots |

## Verification
If a start position is wrong, the error shows up at the ports in the very next registered result. Every slot after the bad one carries shifted halfwords, and a wrong long flag or a wrong word appears in the same cycle, as does a consumed count that no longer matches the valid and long flags. A validity bit that is set wrongly shows up the same way: a gap in the valid pattern, or a consumed count larger than the available count. A wrong stall-hold path shows up as a slot word that changes during a held cycle.

// File: rtl/aligner_pkg.sv
// Shared widths and types for the instruction boundary aligner.
// Assumes halfword-granular instructions of one or two halfwords.
package aligner_pkg;
    localparam int HW_W = 16;          // halfword width
    localparam int IW_W = 2 * HW_W;    // widest instruction word

    typedef logic [HW_W-1:0] hword_t;
    typedef logic [IW_W-1:0] iword_t;
endpackage

// File: rtl/aligner_lenflags.sv
// Forms one length bit per halfword: set when the halfword would open a
// two-halfword instruction. Assumes the length code sits in bits [1:0].
module aligner_lenflags
    import aligner_pkg::*;
#(
    parameter int WIN = 16
) (
    input  hword_t [WIN-1:0] hw_i,
    output logic   [WIN-1:0] long_o
);
    // one AND-reduction per halfword position
    for (genvar i = 0; i < WIN; i++) begin : g_flag
        assign long_o[i] = &hw_i[i][1:0];
    end
endmodule

// File: rtl/aligner_steer.sv
// Prefix over the length bits giving a one-hot start vector for every slot.
// Slot 0 is fixed at halfword 0; a start that would pass the window end
// leaves an all-zero vector. Assumes long_i is valid for all positions.
module aligner_steer #(
    parameter int WIN   = 16,
    parameter int SLOTS = 8
) (
    input  logic [WIN-1:0]            long_i,
    output logic [SLOTS-1:0][WIN-1:0] start_oh_o
);
    // each slot start is the previous start advanced by one or two halfwords
    always_comb begin
        start_oh_o       = '0;
        start_oh_o[0][0] = 1'b1;
        for (int k = 1; k < SLOTS; k++) begin
            start_oh_o[k][1] = start_oh_o[k-1][0] & ~long_i[0];
            for (int p = 2; p < WIN; p++) begin
                start_oh_o[k][p] = (start_oh_o[k-1][p-1] & ~long_i[p-1])
                                 | (start_oh_o[k-1][p-2] &  long_i[p-2]);
            end
        end
    end
endmodule

// File: rtl/aligner_slot_mux.sv
// Steers one instruction into a decode slot using its one-hot start.
// The window is padded with one zero halfword so a 32-bit pick at the
// last position stays in range. Assumes at most one start bit is set.
module aligner_slot_mux
    import aligner_pkg::*;
#(
    parameter int WIN = 16
) (
    input  logic   [WIN-1:0] start_oh_i,
    input  logic   [WIN-1:0] long_i,
    input  logic   [WIN-1:0] fits_i,
    input  hword_t [WIN:0]   hw_ext_i,
    input  logic             prev_valid_i,
    output logic             valid_o,
    output logic             long_o,
    output iword_t           word_o
);
    logic   hit;
    logic   lng;
    iword_t pick;

    // AND-OR selection of the instruction halfwords at the start position
    always_comb begin
        pick = '0;
        for (int p = 0; p < WIN; p++) begin
            if (start_oh_i[p]) begin
                pick = pick | {(long_i[p] ? hw_ext_i[p+1] : hword_t'(0)), hw_ext_i[p]};
            end
        end
    end

    assign hit     = |(start_oh_i & fits_i);
    assign lng     = |(start_oh_i & long_i);
    assign valid_o = prev_valid_i & hit;
    assign long_o  = valid_o & lng;
    assign word_o  = valid_o ? pick : iword_t'(0);
endmodule

// File: rtl/insn_aligner.sv
// Parallel instruction boundary aligner: splits a halfword window into up
// to SLOTS instructions, registers them and reports halfwords consumed.
// Assumes avail_i never exceeds WIN and halfwords below it are fetched data.
module insn_aligner
    import aligner_pkg::*;
#(
    parameter int WIN   = 16,
    parameter int SLOTS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WIN*HW_W-1:0]        win_i,
    input  logic [$clog2(WIN+1)-1:0]   avail_i,
    input  logic                       stall_i,
    output logic [SLOTS-1:0]           slot_valid_o,
    output logic [SLOTS-1:0]           slot_long_o,
    output logic [SLOTS*IW_W-1:0]      slot_word_o,
    output logic [$clog2(WIN+1)-1:0]   consumed_o
);
    localparam int IDX_W = $clog2(WIN+1);

    hword_t [WIN-1:0]             hw;
    hword_t [WIN:0]               hw_ext;
    logic   [WIN-1:0]             long_f;
    logic   [WIN-1:0]             fits;
    logic   [SLOTS-1:0][WIN-1:0]  start_oh;
    logic   [SLOTS:0]             chain;
    logic   [SLOTS-1:0]           valid_c;
    logic   [SLOTS-1:0]           long_c;
    iword_t [SLOTS-1:0]           word_c;
    logic   [IDX_W-1:0]           cons_c;

    logic   [SLOTS-1:0]           valid_q;
    logic   [SLOTS-1:0]           long_q;
    iword_t [SLOTS-1:0]           word_q;
    logic   [IDX_W-1:0]           cons_q;

    assign hw     = win_i;
    assign hw_ext = {hword_t'(0), hw};

    aligner_lenflags #(.WIN(WIN)) u_len (
        .hw_i   (hw),
        .long_o (long_f)
    );

    aligner_steer #(.WIN(WIN), .SLOTS(SLOTS)) u_steer (
        .long_i     (long_f),
        .start_oh_o (start_oh)
    );

    // per position: does an instruction starting here end inside the data
    for (genvar p = 0; p < WIN; p++) begin : g_fit
        assign fits[p] = long_f[p] ? (IDX_W'(p + 1) < avail_i)
                                   : (IDX_W'(p) < avail_i);
    end

    assign chain[0] = 1'b1;
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        aligner_slot_mux #(.WIN(WIN)) u_mux (
            .start_oh_i   (start_oh[k]),
            .long_i       (long_f),
            .fits_i       (fits),
            .hw_ext_i     (hw_ext),
            .prev_valid_i (chain[k]),
            .valid_o      (valid_c[k]),
            .long_o       (long_c[k]),
            .word_o       (word_c[k])
        );
        assign chain[k+1] = valid_c[k];
    end

    // total halfword length of the valid slots
    always_comb begin
        cons_c = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (valid_c[k]) begin
                cons_c = cons_c + (long_c[k] ? IDX_W'(2) : IDX_W'(1));
            end
        end
    end

    // output register: cleared by reset, frozen while decode stalls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            long_q  <= '0;
            word_q  <= '0;
            cons_q  <= '0;
        end else if (!stall_i) begin
            valid_q <= valid_c;
            long_q  <= long_c;
            word_q  <= word_c;
            cons_q  <= cons_c;
        end
    end

    assign slot_valid_o = valid_q;
    assign slot_long_o  = long_q;
    assign slot_word_o  = word_q;
    assign consumed_o   = stall_i ? IDX_W'(0) : cons_q;
endmodule

// File: rtl/insn_aligner_chk.sv
// Port-level property checker for insn_aligner, attached by bind.
// Assumes the same WIN and SLOTS as the instance it watches.
module insn_aligner_chk #(
    parameter int WIN   = 16,
    parameter int SLOTS = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     stall_i,
    input logic [$clog2(WIN+1)-1:0] avail_i,
    input logic [SLOTS-1:0]         slot_valid_o,
    input logic [SLOTS-1:0]         slot_long_o,
    input logic [SLOTS*32-1:0]      slot_word_o,
    input logic [$clog2(WIN+1)-1:0] consumed_o
);
    AST_VALID_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_valid_o + 1'b1) & slot_valid_o) == '0);   // R5

    AST_CONSUMED_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_i |-> int'(consumed_o) == $countones(slot_valid_o) + $countones(slot_long_o));   // R7

    AST_WITHIN_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stall_i) |-> consumed_o <= $past(avail_i));   // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(slot_valid_o) && $stable(slot_long_o) && $stable(slot_word_o));   // R9

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot_chk
        AST_LONG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            slot_long_o[k] |-> slot_word_o[32*k +: 2] == 2'b11);   // R1
        AST_SHORT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid_o[k] && !slot_long_o[k]) |->
                (slot_word_o[32*k +: 2] != 2'b11 && slot_word_o[32*k+16 +: 16] == 16'h0));   // R3
        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_valid_o[k] |-> (slot_word_o[32*k +: 32] == 32'h0 && !slot_long_o[k]));   // R8
    end
endmodule

bind insn_aligner insn_aligner_chk #(.WIN(WIN), .SLOTS(SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall_i      (stall_i),
    .avail_i      (avail_i),
    .slot_valid_o (slot_valid_o),
    .slot_long_o  (slot_long_o),
    .slot_word_o  (slot_word_o),
    .consumed_o   (consumed_o)
);

// File: tb/tb_insn_aligner.sv
`timescale 1ns/1ps
module tb_insn_aligner;
    localparam int WIN   = 16;
    localparam int SLOTS = 8;

    typedef struct packed {
        logic [1:0]   kind;   // 0 normal, 1 stall hold, 2 reset
        logic [7:0]   v;
        logic [7:0]   l;
        logic [255:0] w;
        logic [4:0]   c;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [255:0] win_i;
    logic [4:0]   avail_i;
    logic         stall_i;
    logic [7:0]   slot_valid_o;
    logic [7:0]   slot_long_o;
    logic [255:0] slot_word_o;
    logic [4:0]   consumed_o;

    exp_t exp_q[$];
    exp_t last_exp;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    logic [255:0] wb;
    logic [31:0]  lfsr = 32'hACE1_2357;

    always #2.5 clk = ~clk;

    insn_aligner #(.WIN(WIN), .SLOTS(SLOTS)) dut (
        .clk(clk), .rst_n(rst_n), .win_i(win_i), .avail_i(avail_i),
        .stall_i(stall_i), .slot_valid_o(slot_valid_o), .slot_long_o(slot_long_o),
        .slot_word_o(slot_word_o), .consumed_o(consumed_o)
    );

    // Reference from the requirements: walk halfwords from 0 (R2), length
    // from bits [1:0] (R1), stop at the data edge (R4) or after 8 slots (R6).
    function automatic exp_t model(input logic [255:0] w, input int av);
        exp_t e;
        int pos;
        logic [15:0] h0;
        int len;
        e = '0;
        pos = 0;
        for (int k = 0; k < SLOTS; k++) begin
            if (pos >= av) break;
            h0  = w[pos*16 +: 16];
            len = (h0[1:0] == 2'b11) ? 2 : 1;
            if (pos + len > av) break;
            e.v[k] = 1'b1;
            e.l[k] = (len == 2);
            e.w[k*32 +: 16] = h0;
            if (len == 2) e.w[k*32+16 +: 16] = w[(pos+1)*16 +: 16];
            pos += len;
        end
        e.c = 5'(pos);
        return e;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] expv, input string what);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // driver: present a window with stall low; result due one edge later (R11)
    task automatic apply(input logic [255:0] w, input int av);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b1; stall_i = 1'b0; win_i = w; avail_i = 5'(av);
        e = model(w, av);
        last_exp = e;
        exp_q.push_back(e);
    endtask

    // driver: stall with a different window on the inputs (R9)
    task automatic hold(input logic [255:0] w);
        exp_t e;
        @(negedge clk);
        stall_i = 1'b1; win_i = w; avail_i = 5'd16;
        e = last_exp;
        e.kind = 2'd1;
        e.c = 5'd0;
        exp_q.push_back(e);
    endtask

    // monitor: pop one expected item per edge, compare after outputs settle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                string tv, tl, tw, tc;
                e = exp_q.pop_front();
                tv = "R4"; tl = "R1"; tw = "R2/R3"; tc = "R7";
                if (e.kind == 2'd1) begin tv = "R9"; tl = "R9"; tw = "R9"; tc = "R9"; end
                if (e.kind == 2'd2) begin tv = "R10"; tl = "R10"; tw = "R10"; tc = "R10"; end
                for (int k = 0; k < SLOTS; k++) begin
                    check(tv, 256'(slot_valid_o[k]), 256'(e.v[k]), $sformatf("slot %0d valid", k));
                    check(tl, 256'(slot_long_o[k]), 256'(e.l[k]), $sformatf("slot %0d long", k));
                    // invalid slots must read zero (R8)
                    check((e.kind == 2'd0 && !e.v[k]) ? "R8" : tw,
                          256'(slot_word_o[k*32 +: 32]), 256'(e.w[k*32 +: 32]),
                          $sformatf("slot %0d word", k));
                end
                check(tc, 256'(consumed_o), 256'(e.c), "consumed");
            end
        end
    end

    task automatic set_hw(input int i, input logic [15:0] v);
        wb[i*16 +: 16] = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        exp_t z;
        rst_n = 1'b0; stall_i = 1'b0; win_i = '1; avail_i = 5'd16;
        z = '0; z.kind = 2'd2;
        last_exp = '0;
        exp_q.push_back(z);          // R10 reset state
        @(negedge clk);
        exp_q.push_back(z);          // second reset cycle
        // all 16-bit, codes 00/01/10: eight slots, consumed 8 (R6)
        for (int i = 0; i < WIN; i++) set_hw(i, {14'(i + 16'h0100), 2'(i % 3)});
        apply(wb, 16);
        // all 32-bit: eight slots over all 16 halfwords
        for (int i = 0; i < WIN; i++) set_hw(i, {14'(16'h2A00 + i), 2'b11});
        apply(wb, 16);
        // seven longs, a short at 14, a long at 15 left for next cycle (R4)
        for (int i = 0; i < WIN; i++) set_hw(i, {14'(16'h1230 + i), 2'b11});
        set_hw(14, 16'hBEE1);
        apply(wb, 16);
        // long at 0 and 2 with three halfwords available: one slot
        for (int i = 0; i < WIN; i++) set_hw(i, {14'(16'h0770 + i), 2'b11});
        apply(wb, 3);
        // nothing available
        apply(wb, 0);
        // a long instruction at the last available halfword is held back
        apply(wb, 1);
        // mixed lengths, short codes of every kind
        for (int i = 0; i < WIN; i++) set_hw(i, {14'(16'h3C00 + 7 * i), 2'((i * 5) % 4)});
        apply(wb, 16);
        apply(wb, 9);
        // stall twice with new windows presented; outputs hold (R9)
        hold(~wb);
        hold({wb[127:0], wb[255:128]});
        for (int i = 0; i < WIN; i++) set_hw(i, {14'(16'h0F00 + i), 2'b10});
        apply(wb, 5);
        // pseudo-random windows and fill levels
        for (int n = 0; n < 160; n++) begin
            for (int i = 0; i < WIN; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                set_hw(i, lfsr[15:0] ^ lfsr[31:16]);
            end
            if (n % 11 == 5) hold(wb);
            else apply(wb, (n % 4 == 0) ? int'(lfsr[3:0]) + 1 : 16);
        end
        @(negedge clk);
        stall_i = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        finish_run();
    end
endmodule